// File: doc/BRIEF.md
# Dual-Channel Burst DMA Arbiter

This block is a host-side DMA master for two peripherals that share a single 32-bit data bus. Each peripheral holds a request line high when it has a burst ready. The arbiter grants one peripheral at a time by raising that peripheral's acknowledge. It then paces a fixed number of data strobes across the shared bus. Each word is carried between the bus and a synchronous memory port.

A static direction input selects between two transfer directions:
- Upload direction: read strobes pull words off the peripheral bus, and each word is written into memory.
- Download direction: each word is fetched from memory one slot ahead of a write strobe to the peripheral.

Each peripheral owns a memory region. The region is defined by a base address and an auto-incrementing word count, so data from the two peripherals never interleave in memory.

The first request to arrive wins. After that, service alternates whenever both peripherals are waiting. A programmable divider stretches each access slot so that the strobe rate stays below what the peripherals tolerate. A burst-length setting is clamped to the largest legal burst.

Top module: `dma_burst_arb`

## Requirements
- R1: While rst_n is low, dack is 00, dev_rd, dev_wr and mem_req are 0, and both word counters read 0.
- R2: A grant raises only dack[i] of a channel whose request was high in the cycle before. At most one dack bit is ever high. dack stays high for the whole burst, whether or not the request drops.
- R3: A grant carries exactly L strobes. L is 1 when len_cfg is 0, 256 when len_cfg exceeds 256, and len_cfg otherwise.
- R4: Each access takes P cycles, with P = max(div_cfg,1)+1. The strobe is high only in the last cycle of each access, so the first strobe falls in the P-th cycle that dack is high.
- R5: With dir_wr = 0, every strobe is on dev_rd. In that same cycle mem_req = mem_we = 1 and mem_wdata equals dev_rdata.
- R6: With dir_wr = 1, every strobe is on dev_wr. A memory read (mem_req = 1, mem_we = 0) is issued in the first cycle of each access, and dev_wdata carries mem_rdata, which the memory returns one cycle after the request.
- R7: If both requests are high and no grant has happened since reset, channel 0 is granted.
- R8: After any grant, if both requests are high, the channel not served last is granted. A lone request is always granted.
- R9: Every memory access of channel i uses address base_i + words_i, modulo 2^16. words_i is the count before that access.
- R10: words0 and words1 each count the strobes of their own channel since reset, stepping by exactly one.
- R11: Between two grants, at least one cycle has dack = 00. A grant never switches directly to the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_wr | input | 1 | 0: peripheral-to-memory, 1: memory-to-peripheral (static) |
| div_cfg | input | 8 | Access slot length minus one (0 treated as 1) |
| len_cfg | input | 9 | Words per burst (0 treated as 1, above 256 clamped) |
| base0 | input | 16 | Memory base address of channel 0 |
| base1 | input | 16 | Memory base address of channel 1 |
| dreq | input | 2 | Level-held burst requests, one per peripheral |
| dack | output | 2 | Burst acknowledge, one per peripheral |
| dev_rd | output | 1 | Read strobe on the shared bus |
| dev_wr | output | 1 | Write strobe on the shared bus |
| dev_rdata | input | 32 | Data driven by the granted peripheral |
| dev_wdata | output | 32 | Data driven to the granted peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| words0 | output | 16 | Words moved by channel 0 since reset |
| words1 | output | 16 | Words moved by channel 1 since reset |

## Verification
The hardest situations to reach are the two tie-breaks:
- both requests rising in the very first cycle after reset;
- both requests pending at the idle cycle that ends a burst.

The stimulus gets to both. It raises the two requests together straight out of reset. It also gives each peripheral several queued bursts, so its line stays high across consecutive grants. A third case adds the second request partway through a running burst, so that the tie is met exactly at the gap cycle. The download runs also exercise the one-cycle memory latency against the slowest and the shortest slot lengths, and a clamped 256-word burst is included.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH = 2;
  typedef enum logic {PH_IDLE = 1'b0, PH_BURST = 1'b1} burst_st_e;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick (
  input  logic [1:0] req,
  input  logic       last,
  output logic       any,
  output logic       pick
);
  always_comb begin
    any = |req;
    if (req == 2'b11) pick = ~last;
    else              pick = req[1];
  end
endmodule

// File: rtl/dma_arb_pacer.sv
module dma_arb_pacer #(
  parameter int DIVW   = 8,
  parameter int LENW   = 9,
  parameter int MAXLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DIVW-1:0] div_cfg,
  input  logic [LENW-1:0] len_cfg,
  output logic            busy,
  output logic            strobe,
  output logic            first_ph
);
  import dma_arb_pkg::*;
  localparam logic [LENW-1:0] LEN_CAP = LENW'(MAXLEN);

  burst_st_e       st_q, st_d;
  logic [DIVW-1:0] ph_q, ph_d, per_m1;
  logic [LENW-1:0] wd_q, wd_d, len_m1;
  logic            last_word;

  always_comb begin
    per_m1 = (div_cfg == '0) ? DIVW'(1) : div_cfg;
    if (len_cfg == '0)          len_m1 = '0;
    else if (len_cfg > LEN_CAP) len_m1 = LEN_CAP - 1'b1;
    else                        len_m1 = len_cfg - 1'b1;
  end

  assign busy      = (st_q == PH_BURST);
  assign strobe    = busy && (ph_q == per_m1);
  assign first_ph  = busy && (ph_q == '0);
  assign last_word = (wd_q == len_m1);

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    wd_d = wd_q;
    if (!busy) begin
      if (start) begin
        st_d = PH_BURST;
        ph_d = '0;
        wd_d = '0;
      end
    end else if (strobe) begin
      if (last_word) begin
        st_d = PH_IDLE;
      end else begin
        wd_d = wd_q + 1'b1;
        ph_d = '0;
      end
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
      ph_q <= '0;
      wd_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      wd_q <= wd_d;
    end
  end
endmodule

// File: rtl/dma_arb_chan.sv
module dma_arb_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] off;

  generate
    if (CW >= AW) begin : g_trunc
      assign off = cnt_q[AW-1:0];
    end else begin : g_ext
      assign off = {{(AW-CW){1'b0}}, cnt_q};
    end
  endgenerate

  always_comb cnt_d = inc ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign addr  = base + off;
  assign count = cnt_q;
endmodule

// File: rtl/dma_burst_arb.sv
module dma_burst_arb #(
  parameter int DW     = 32,
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int DIVW   = 8,
  parameter int LENW   = 9,
  parameter int MAXLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_wr,
  input  logic [DIVW-1:0] div_cfg,
  input  logic [LENW-1:0] len_cfg,
  input  logic [AW-1:0]   base0,
  input  logic [AW-1:0]   base1,
  input  logic [1:0]      dreq,
  output logic [1:0]      dack,
  output logic            dev_rd,
  output logic            dev_wr,
  input  logic [DW-1:0]   dev_rdata,
  output logic [DW-1:0]   dev_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [CW-1:0]   words0,
  output logic [CW-1:0]   words1
);
  import dma_arb_pkg::*;

  logic          any_req, pick, start;
  logic          sel_q, sel_d;
  logic          busy, strobe, first_ph;
  logic [AW-1:0] base_w [NCH];
  logic [AW-1:0] addr_w [NCH];
  logic [CW-1:0] cnt_w  [NCH];

  dma_arb_pick u_pick (
    .req  (dreq),
    .last (sel_q),
    .any  (any_req),
    .pick (pick)
  );

  assign start = any_req && !busy;

  always_comb sel_d = start ? pick : sel_q;

  // channel 0 wins the very first tie: pretend channel 1 was served last
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b1;
    else        sel_q <= sel_d;
  end

  dma_arb_pacer #(.DIVW(DIVW), .LENW(LENW), .MAXLEN(MAXLEN)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .div_cfg  (div_cfg),
    .len_cfg  (len_cfg),
    .busy     (busy),
    .strobe   (strobe),
    .first_ph (first_ph)
  );

  assign base_w[0] = base0;
  assign base_w[1] = base1;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma_arb_chan #(.AW(AW), .CW(CW)) u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (strobe && (sel_q == 1'(i))),
        .base  (base_w[i]),
        .addr  (addr_w[i]),
        .count (cnt_w[i])
      );
    end
  endgenerate

  assign dack      = busy ? (sel_q ? 2'b10 : 2'b01) : 2'b00;
  assign dev_rd    = strobe && !dir_wr;
  assign dev_wr    = strobe && dir_wr;
  assign mem_req   = dir_wr ? first_ph : strobe;
  assign mem_we    = strobe && !dir_wr;
  assign mem_addr  = sel_q ? addr_w[1] : addr_w[0];
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign words0    = cnt_w[0];
  assign words1    = cnt_w[1];
endmodule

// File: rtl/dma_burst_arb_chk.sv
module dma_burst_arb_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_wr,
  input logic [1:0]    dreq,
  input logic [1:0]    dack,
  input logic          dev_rd,
  input logic          dev_wr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [CW-1:0] words0,
  input logic [CW-1:0] words1
);
  // R2
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
  // R2
  grant0_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack[0]) |-> $past(dreq[0]));
  // R2
  grant1_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack[1]) |-> $past(dreq[1]));
  // R4
  strobe_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd || dev_wr) |-> (dack != 2'b00));
  // R5
  rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |-> (!dir_wr && mem_req && mem_we));
  // R6
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> (dir_wr && !mem_we));
  // R11
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dack[0]) || $fell(dack[1])) |-> (dack == 2'b00));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(dack) != 2'b00) && (dack != 2'b00)) |-> (dack == $past(dack)));
  // R10
  cnt0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (words0 != $past(words0)) |->
      ((words0 == $past(words0) + 1'b1) && $past(dack[0] && (dev_rd || dev_wr))));
  // R10
  cnt1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (words1 != $past(words1)) |->
      ((words1 == $past(words1) + 1'b1) && $past(dack[1] && (dev_rd || dev_wr))));
endmodule

bind dma_burst_arb dma_burst_arb_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dir_wr  (dir_wr),
  .dreq    (dreq),
  .dack    (dack),
  .dev_rd  (dev_rd),
  .dev_wr  (dev_wr),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .words0  (words0),
  .words1  (words1)
);

// File: tb/sim_dma_burst_arb.sv
module sim_dma_burst_arb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_wr = 1'b0;
  logic [7:0]  div_cfg = 8'd0;
  logic [8:0]  len_cfg = 9'd8;
  logic [15:0] base0 = 16'h1000;
  logic [15:0] base1 = 16'h8000;
  logic [1:0]  dreq = 2'b00;
  logic [1:0]  dack;
  logic        dev_rd, dev_wr, mem_req, mem_we;
  logic [31:0] dev_rdata = 32'h0;
  logic [31:0] dev_wdata, mem_wdata;
  logic [31:0] mem_rdata = 32'h0;
  logic [15:0] mem_addr, words0, words1;

  dma_burst_arb u0 (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .div_cfg(div_cfg), .len_cfg(len_cfg),
    .base0(base0), .base1(base1), .dreq(dreq), .dack(dack), .dev_rd(dev_rd),
    .dev_wr(dev_wr), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .words0(words0), .words1(words1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int pend [2] = '{0, 0};
  bit taken [2] = '{0, 0};
  int m_cnt [2] = '{0, 0};
  bit m_busy = 0, m_ch = 0, m_last = 1;
  int m_ph = 0, m_wd = 0;
  logic [15:0] m_raddr = 16'h0;

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a, 16'h0} ^ ({16'h0, a} * 32'd40503) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, evaluated away from the active edge
  always @(negedge clk) begin
    int pm1, lm1;
    bit e_str, e_mreq;
    logic [1:0] e_dack;
    logic [15:0] e_addr;
    cyc++;
    if (!rst_n) begin
      chk(dack == 2'b00 && !dev_rd && !dev_wr && !mem_req && words0 == 0 && words1 == 0,
          "R1 reset state", {dack, dev_rd, dev_wr, mem_req, words0, words1}, 64'h0);
    end else begin
      pm1 = (div_cfg == 0) ? 1 : int'(div_cfg);
      lm1 = (len_cfg == 0) ? 0 : ((len_cfg > 256) ? 255 : int'(len_cfg) - 1);
      e_str  = m_busy && (m_ph == pm1);
      e_dack = m_busy ? (m_ch ? 2'b10 : 2'b01) : 2'b00;
      e_mreq = dir_wr ? (m_busy && m_ph == 0) : e_str;
      e_addr = 16'((m_ch ? int'(base1) : int'(base0)) + m_cnt[m_ch]);
      chk(dack === e_dack, "R2 R7 R8 R11 dack", dack, e_dack);
      chk(dev_rd === (e_str && !dir_wr) && dev_wr === (e_str && dir_wr),
          "R4 strobes", {dev_rd, dev_wr}, {e_str && !dir_wr, e_str && dir_wr});
      chk(mem_req === e_mreq && mem_we === (e_str && !dir_wr),
          "R5 R6 mem ctl", {mem_req, mem_we}, {e_mreq, e_str && !dir_wr});
      if (e_mreq) chk(mem_addr === e_addr, "R9 address", mem_addr, e_addr);
      if (e_str && !dir_wr) chk(mem_wdata === dev_rdata, "R5 upload data", mem_wdata, dev_rdata);
      if (e_str && dir_wr) chk(dev_wdata === memf(m_raddr), "R6 download data", dev_wdata, memf(m_raddr));
      chk(int'(words0) == m_cnt[0] && int'(words1) == m_cnt[1], "R10 word counters",
          {words0, words1}, {m_cnt[0][15:0], m_cnt[1][15:0]});
      // memory with one cycle of read latency
      if (e_mreq && dir_wr) begin
        m_raddr   = e_addr;
        mem_rdata = memf(e_addr);
      end
      // peripherals: drop request once a strobe of their grant is seen
      for (int i = 0; i < 2; i++) begin
        if (e_dack[i] && e_str && !taken[i]) begin
          taken[i] = 1;
          pend[i]--;
          dreq[i] = (pend[i] > 0);
        end
        if (!e_dack[i]) taken[i] = 0;
      end
      dev_rdata = {8'hC3, 8'(cyc * 7), 16'(cyc)};
      // advance the model over the coming edge
      if (!m_busy) begin
        if (dreq != 2'b00) begin
          m_ch   = (dreq == 2'b11) ? !m_last : dreq[1];
          m_last = m_ch;
          m_busy = 1;
          m_ph   = 0;
          m_wd   = 0;
        end
      end else if (m_ph == pm1) begin
        m_cnt[m_ch]++;
        if (m_wd == lm1) m_busy = 0;
        else begin
          m_wd++;
          m_ph = 0;
        end
      end else begin
        m_ph++;
      end
    end
    if (cyc > WATCHDOG) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic request(input int ch, input int n);
    pend[ch] += n;
    dreq[ch] = 1'b1;
  endtask

  task automatic drain();
    do @(posedge clk); while (pend[0] != 0 || pend[1] != 0 || m_busy);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic totals(input int e0, input int e1, input string tag);
    chk(int'(words0) == e0, tag, words0, e0);
    chk(int'(words1) == e1, tag, words1, e1);
  endtask

  initial begin
    #(CLK_PERIOD * 11 + 2);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R7: both raised together straight out of reset, R8 alternation
    request(0, 2); request(1, 2);
    drain();
    totals(16, 16, "R3 R7 R8 totals 8-word bursts");
    // lone channel 1, repeated bursts, slot of 3
    div_cfg = 8'd2;
    request(1, 3);
    drain();
    totals(16, 40, "R3 R8 lone requester");
    // download direction, slot of 4, both queued
    dir_wr = 1'b1; div_cfg = 8'd3;
    request(0, 2); request(1, 2);
    drain();
    totals(32, 56, "R3 R6 download totals");
    // zero length is one word
    len_cfg = 9'd0; div_cfg = 8'd0;
    request(0, 2);
    drain();
    totals(34, 56, "R3 zero length clamp");
    // oversize length clamps to 256
    dir_wr = 1'b0; len_cfg = 9'd300;
    request(1, 1);
    drain();
    totals(34, 312, "R3 oversize clamp");
    // second request arrives mid-burst, tie at the gap cycle
    dir_wr = 1'b1; len_cfg = 9'd5; div_cfg = 8'd1;
    request(1, 2);
    repeat (4) @(posedge clk); #1;
    request(0, 1);
    drain();
    totals(39, 322, "R3 R8 R11 mid-burst arrival");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule